// File: doc/BRIEF.md
# SPI Control-Port Frame Decoder

This block is the serial front end of an audio signal processor's control port. It samples an SPI bus (mode 0, most significant bit first, active-low chip select) in the system clock domain and collects bytes. It reads a two-byte header that carries a direction flag and a 10-bit register address, then picks one of three frame formats from it. The three formats set up the data-capture trap, load a parameter for a safe update, or read back a 24-bit captured word.

Completed write frames produce a one-cycle strobe plus registered fields for the capture and safeload logic. Completed reads produce a one-cycle strobe when the captured word is taken. A lockout input from the boot sequencer blocks every access while the power-up initialization runs. Raising chip select early abandons the frame without side effects.

Top module: `spi_ctl_port`

## Requirements
- R1: MOSI is sampled on rising SCLK edges while chip select is low, most significant bit first. In header byte 0, bits 7:3 must be zero, bit 2 is the direction (1 = read, 0 = write) and bits 1:0 are address bits 9:8. Byte 1 is address bits 7:0. A frame whose byte 0 has any nonzero bit in 7:3 causes no strobe.
- R2: A write to CAP_ADDR takes program-counter bits 8:6 from bits 2:0 of byte 2. Byte 3 bits 7:2 give program-counter bits 5:0 and bits 1:0 give the register select. When byte 3 completes, `cap_wr_o` pulses and `cap_pc_o` and `cap_sel_o` take the new values.
- R3: A write to SAFE_ADDR takes the parameter address from byte 2, parameter bits 21:16 from byte 3 bits 5:0, bits 15:8 from byte 4 and bits 7:0 from byte 5. When byte 5 completes, `safe_wr_o` pulses and `safe_addr_o` and `safe_data_o` take the new values.
- R4: A read of CAP_ADDR takes `cap_rd_data_i` at the end of byte 2 and pulses `cap_rd_o` once. The word goes out on MISO as bytes 3, 4 and 5, most significant bit first. Each bit is valid before the rising SCLK edge that samples it, and the first is valid before the first edge of byte 3.
- R5: Chip select going high before the last byte of a format ends the frame with no strobe and no change to any field. The next frame is decoded from its byte 0 again.
- R6: A frame whose direction and address match none of the three formats (including a read of SAFE_ADDR) causes no strobe and leaves MISO at zero.
- R7: If `boot_busy_i` is high at any time between chip select falling and the completion of the final byte, the frame issues no strobe, leaves all fields unchanged and reads back zeros.
- R8: MISO is zero while chip select is high, during header and byte 2 of a read, and for any byte after the 24 data bits.
- R9: Strobes last one cycle and at most one is high at a time. Output fields change only in the cycle their strobe is high. Bytes beyond a format's length have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, must run at least 8x SCLK |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_busy_i | input | 1 | High while the boot sequence runs; blocks accesses |
| spi_sclk_i | input | 1 | SPI serial clock |
| spi_cs_ni | input | 1 | SPI chip select, active low |
| spi_mosi_i | input | 1 | SPI data from host |
| spi_miso_o | output | 1 | SPI data to host |
| cap_rd_data_i | input | 24 | Captured word offered for read-back |
| cap_wr_o | output | 1 | Capture setup strobe |
| cap_pc_o | output | 9 | Program-counter value at which capture fires |
| cap_sel_o | output | 2 | Which of four internal registers to capture |
| cap_rd_o | output | 1 | Captured word taken for read-back |
| safe_wr_o | output | 1 | Safeload strobe |
| safe_addr_o | output | 8 | Safeload parameter address |
| safe_data_o | output | 22 | Safeload parameter value |

## Verification
The assertions watch, on every cycle, that strobes are single-cycle and mutually exclusive, and that no strobe follows a cycle with the boot lockout high. They also check that output fields move only with their strobe and that MISO stays low once chip select has been high for a few cycles. The bench scenarios are needed for the rest: correct field extraction from each byte layout, the bit order and timing of read data on MISO, abandoned frames, unknown addresses, nonzero reserved header bits, and a lockout pulse that arrives in the middle of a frame.

// File: rtl/spi_ctl_pkg.sv
package spi_ctl_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = 10;
  localparam int PC_W    = 9;
  localparam int SEL_W   = 2;
  localparam int PADDR_W = 8;
  localparam int PDATA_W = 22;
  localparam int CAP_W   = 24;
  localparam int IDX_W   = 3;
  localparam int BIT_W   = $clog2(BYTE_W);

  typedef enum logic [1:0] {
    FR_NONE    = 2'd0,
    FR_CAP_WR  = 2'd1,
    FR_SAFE_WR = 2'd2,
    FR_CAP_RD  = 2'd3
  } frame_kind_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int             N       = 3,
  parameter int             STAGES  = 2,
  parameter logic [N-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] din_i,
  output logic [N-1:0] sync_o,
  output logic [N-1:0] prev_o
);
  logic [N-1:0] stg [STAGES+1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s <= STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= din_i;
      for (int s = 1; s <= STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign sync_o = stg[STAGES-1];
  assign prev_o = stg[STAGES];
endmodule

// File: rtl/spi_byte_rx.sv
module spi_byte_rx import spi_ctl_pkg::*; (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              rise_i,
  input  logic              mosi_i,
  output logic              byte_done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic [BIT_W-1:0]  bit_cnt_q;
  logic [IDX_W-1:0]  idx_cnt_q;
  logic [BYTE_W-2:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q   <= '0;
      idx_cnt_q   <= '0;
      sh_q        <= '0;
      byte_o      <= '0;
      idx_o       <= '0;
      byte_done_o <= 1'b0;
    end else begin
      byte_done_o <= 1'b0;
      if (!cs_act_i) begin
        bit_cnt_q <= '0;
        idx_cnt_q <= '0;
      end else if (rise_i) begin
        sh_q      <= {sh_q[BYTE_W-3:0], mosi_i};
        bit_cnt_q <= bit_cnt_q + 1'b1;
        if (bit_cnt_q == BIT_W'(BYTE_W-1)) begin
          byte_o      <= {sh_q, mosi_i};
          idx_o       <= idx_cnt_q;
          byte_done_o <= 1'b1;
          // saturate: bytes past the longest format are all "late"
          if (idx_cnt_q != '1) idx_cnt_q <= idx_cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_frame_dec.sv
module spi_frame_dec import spi_ctl_pkg::*; #(
  parameter logic [ADDR_W-1:0] CAP_ADDR  = 10'h201,
  parameter logic [ADDR_W-1:0] SAFE_ADDR = 10'h210
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cs_act_i,
  input  logic               boot_busy_i,
  input  logic               byte_done_i,
  input  logic [BYTE_W-1:0]  byte_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic               load_o,
  output logic               cap_wr_o,
  output logic [PC_W-1:0]    cap_pc_o,
  output logic [SEL_W-1:0]   cap_sel_o,
  output logic               cap_rd_o,
  output logic               safe_wr_o,
  output logic [PADDR_W-1:0] safe_addr_o,
  output logic [PDATA_W-1:0] safe_data_o
);
  localparam int PC_LO_W  = BYTE_W - SEL_W;
  localparam int PC_HI_W  = PC_W - PC_LO_W;
  localparam int PD_HI_W  = PDATA_W - 2 * BYTE_W;
  localparam int AHI_W    = ADDR_W - BYTE_W;
  localparam int RSV_W    = BYTE_W - AHI_W - 1;

  frame_kind_e         kind_q, kind_dec;
  logic                hdr_ok_q, rd_q, locked_q, ok;
  logic [AHI_W-1:0]    ahi_q;
  logic [PC_HI_W-1:0]  pc_hi_q;
  logic [PADDR_W-1:0]  pa_q;
  logic [PD_HI_W-1:0]  pd_hi_q;
  logic [BYTE_W-1:0]   pd_mid_q;
  logic [ADDR_W-1:0]   hdr_addr;

  assign ok       = !locked_q && !boot_busy_i;
  assign hdr_addr = {ahi_q, byte_i};

  always_comb begin
    kind_dec = FR_NONE;
    if (hdr_ok_q) begin
      if (!rd_q && hdr_addr == CAP_ADDR)  kind_dec = FR_CAP_WR;
      if (!rd_q && hdr_addr == SAFE_ADDR) kind_dec = FR_SAFE_WR;
      if (rd_q  && hdr_addr == CAP_ADDR)  kind_dec = FR_CAP_RD;
    end
  end

  assign load_o = cs_act_i && byte_done_i && idx_i == IDX_W'(2) &&
                  kind_q == FR_CAP_RD && ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kind_q      <= FR_NONE;
      hdr_ok_q    <= 1'b0;
      rd_q        <= 1'b0;
      ahi_q       <= '0;
      locked_q    <= 1'b0;
      pc_hi_q     <= '0;
      pa_q        <= '0;
      pd_hi_q     <= '0;
      pd_mid_q    <= '0;
      cap_wr_o    <= 1'b0;
      cap_pc_o    <= '0;
      cap_sel_o   <= '0;
      cap_rd_o    <= 1'b0;
      safe_wr_o   <= 1'b0;
      safe_addr_o <= '0;
      safe_data_o <= '0;
    end else begin
      cap_wr_o  <= 1'b0;
      safe_wr_o <= 1'b0;
      cap_rd_o  <= load_o;
      if (!cs_act_i) begin
        kind_q   <= FR_NONE;
        locked_q <= 1'b0;
      end else begin
        locked_q <= locked_q | boot_busy_i;
        if (byte_done_i) begin
          case (idx_i)
            IDX_W'(0): begin
              hdr_ok_q <= (byte_i[BYTE_W-1 -: RSV_W] == '0);
              rd_q     <= byte_i[AHI_W];
              ahi_q    <= byte_i[AHI_W-1:0];
            end
            IDX_W'(1): kind_q <= kind_dec;
            IDX_W'(2): begin
              if (kind_q == FR_CAP_WR)  pc_hi_q <= byte_i[PC_HI_W-1:0];
              if (kind_q == FR_SAFE_WR) pa_q    <= byte_i[PADDR_W-1:0];
            end
            IDX_W'(3): begin
              if (kind_q == FR_CAP_WR && ok) begin
                cap_pc_o  <= {pc_hi_q, byte_i[BYTE_W-1:SEL_W]};
                cap_sel_o <= byte_i[SEL_W-1:0];
                cap_wr_o  <= 1'b1;
              end
              if (kind_q == FR_SAFE_WR) pd_hi_q <= byte_i[PD_HI_W-1:0];
            end
            IDX_W'(4): if (kind_q == FR_SAFE_WR) pd_mid_q <= byte_i;
            IDX_W'(5): begin
              if (kind_q == FR_SAFE_WR && ok) begin
                safe_addr_o <= pa_q;
                safe_data_o <= {pd_hi_q, pd_mid_q, byte_i};
                safe_wr_o   <= 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/spi_tx_shift.sv
module spi_tx_shift import spi_ctl_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_act_i,
  input  logic             load_i,
  input  logic [CAP_W-1:0] data_i,
  input  logic             shift_i,
  output logic             miso_o
);
  logic [CAP_W-1:0] sh_q;
  logic             act_q;

  // shift after the host's sampling edge, so the next bit settles before the next rise
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      act_q <= 1'b0;
    end else if (!cs_act_i) begin
      sh_q  <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      sh_q  <= data_i;
      act_q <= 1'b1;
    end else if (shift_i && act_q) begin
      sh_q  <= {sh_q[CAP_W-2:0], 1'b0};
    end
  end

  assign miso_o = act_q & sh_q[CAP_W-1];
endmodule

// File: rtl/spi_ctl_port.sv
module spi_ctl_port import spi_ctl_pkg::*; #(
  parameter logic [ADDR_W-1:0] CAP_ADDR    = 10'h201,
  parameter logic [ADDR_W-1:0] SAFE_ADDR   = 10'h210,
  parameter int                SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               boot_busy_i,
  input  logic               spi_sclk_i,
  input  logic               spi_cs_ni,
  input  logic               spi_mosi_i,
  output logic               spi_miso_o,
  input  logic [CAP_W-1:0]   cap_rd_data_i,
  output logic               cap_wr_o,
  output logic [PC_W-1:0]    cap_pc_o,
  output logic [SEL_W-1:0]   cap_sel_o,
  output logic               cap_rd_o,
  output logic               safe_wr_o,
  output logic [PADDR_W-1:0] safe_addr_o,
  output logic [PDATA_W-1:0] safe_data_o
);
  localparam int PIN_CS   = 2;
  localparam int PIN_SCLK = 1;
  localparam int PIN_MOSI = 0;

  logic [2:0]        pin_s, pin_p;
  logic              cs_act, sclk_rise;
  logic              byte_done, load;
  logic [BYTE_W-1:0] rx_byte;
  logic [IDX_W-1:0]  rx_idx;

  spi_pin_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .din_i  ({spi_cs_ni, spi_sclk_i, spi_mosi_i}),
    .sync_o (pin_s),
    .prev_o (pin_p)
  );

  assign cs_act    = !pin_s[PIN_CS];
  assign sclk_rise = pin_s[PIN_SCLK] && !pin_p[PIN_SCLK];

  spi_byte_rx u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_act_i    (cs_act),
    .rise_i      (sclk_rise),
    .mosi_i      (pin_s[PIN_MOSI]),
    .byte_done_o (byte_done),
    .byte_o      (rx_byte),
    .idx_o       (rx_idx)
  );

  spi_frame_dec #(.CAP_ADDR(CAP_ADDR), .SAFE_ADDR(SAFE_ADDR)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_act_i    (cs_act),
    .boot_busy_i (boot_busy_i),
    .byte_done_i (byte_done),
    .byte_i      (rx_byte),
    .idx_i       (rx_idx),
    .load_o      (load),
    .cap_wr_o    (cap_wr_o),
    .cap_pc_o    (cap_pc_o),
    .cap_sel_o   (cap_sel_o),
    .cap_rd_o    (cap_rd_o),
    .safe_wr_o   (safe_wr_o),
    .safe_addr_o (safe_addr_o),
    .safe_data_o (safe_data_o)
  );

  spi_tx_shift u_tx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cs_act_i (cs_act),
    .load_i   (load),
    .data_i   (cap_rd_data_i),
    .shift_i  (sclk_rise),
    .miso_o   (spi_miso_o)
  );
endmodule

// File: rtl/spi_ctl_port_chk.sv
module spi_ctl_port_chk import spi_ctl_pkg::*; (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               boot_busy_i,
  input logic               spi_cs_ni,
  input logic               spi_miso_o,
  input logic               cap_wr_o,
  input logic [PC_W-1:0]    cap_pc_o,
  input logic [SEL_W-1:0]   cap_sel_o,
  input logic               cap_rd_o,
  input logic               safe_wr_o,
  input logic [PADDR_W-1:0] safe_addr_o,
  input logic [PDATA_W-1:0] safe_data_o
);
  assert_strobe_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_wr_o || safe_wr_o) |=> !(cap_wr_o || safe_wr_o));

  assert_strobe_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cap_wr_o, safe_wr_o, cap_rd_o}));

  assert_no_strobe_in_boot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_wr_o || safe_wr_o || cap_rd_o) |-> !$past(boot_busy_i));

  assert_miso_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_cs_ni && $past(spi_cs_ni) && $past(spi_cs_ni, 2) && $past(spi_cs_ni, 3))
      |-> !spi_miso_o);

  assert_cap_fields_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_wr_o |-> ($stable(cap_pc_o) && $stable(cap_sel_o)));

  assert_safe_fields_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !safe_wr_o |-> ($stable(safe_addr_o) && $stable(safe_data_o)));
endmodule

bind spi_ctl_port spi_ctl_port_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .boot_busy_i (boot_busy_i),
  .spi_cs_ni   (spi_cs_ni),
  .spi_miso_o  (spi_miso_o),
  .cap_wr_o    (cap_wr_o),
  .cap_pc_o    (cap_pc_o),
  .cap_sel_o   (cap_sel_o),
  .cap_rd_o    (cap_rd_o),
  .safe_wr_o   (safe_wr_o),
  .safe_addr_o (safe_addr_o),
  .safe_data_o (safe_data_o)
);

// File: tb/spi_ctl_port_bench.sv
`timescale 1ns/1ps
module spi_ctl_port_bench;
  localparam logic [9:0] CAP  = 10'h201;
  localparam logic [9:0] SAFE = 10'h210;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_n = 1'b0, boot_busy = 1'b0;
  logic spi_sclk = 1'b0, spi_cs = 1'b1, spi_mosi = 1'b0;
  logic spi_miso;
  logic [23:0] cap_word = '0;
  logic cap_wr, cap_rd, safe_wr;
  logic [8:0]  cap_pc;
  logic [1:0]  cap_sel;
  logic [7:0]  safe_addr;
  logic [21:0] safe_data;

  int n_cmp = 0, n_bad = 0;
  int cnt_cw = 0, cnt_sw = 0, cnt_cr = 0;
  bit done = 0;
  logic [7:0] tx_b [0:7];
  logic [7:0] rx_b [0:7];
  logic [8:0]  exp_pc = '0;
  logic [1:0]  exp_sel = '0;
  logic [7:0]  exp_pa = '0;
  logic [21:0] exp_pd = '0;

  always #2 clk = ~clk;

  spi_ctl_port #(.CAP_ADDR(CAP), .SAFE_ADDR(SAFE)) u_spi_ctl_port (
    .clk_i(clk), .rst_ni(rst_n), .boot_busy_i(boot_busy),
    .spi_sclk_i(spi_sclk), .spi_cs_ni(spi_cs), .spi_mosi_i(spi_mosi),
    .spi_miso_o(spi_miso), .cap_rd_data_i(cap_word),
    .cap_wr_o(cap_wr), .cap_pc_o(cap_pc), .cap_sel_o(cap_sel), .cap_rd_o(cap_rd),
    .safe_wr_o(safe_wr), .safe_addr_o(safe_addr), .safe_data_o(safe_data)
  );

  always @(posedge clk) begin
    if (cap_wr)  cnt_cw++;
    if (safe_wr) cnt_sw++;
    if (cap_rd)  cnt_cr++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hdr(input logic rd, input logic [9:0] a);
    tx_b[0] = {5'b0, rd, a[9:8]};
    tx_b[1] = a[7:0];
  endtask

  task automatic xfer(input int n);
    @(negedge clk); spi_cs = 1'b0;
    repeat (4) @(negedge clk);
    for (int b = 0; b < n; b++)
      for (int i = 7; i >= 0; i--) begin
        spi_mosi = tx_b[b][i]; spi_sclk = 1'b0;
        repeat (HALF) @(negedge clk);
        rx_b[b][i] = spi_miso; spi_sclk = 1'b1;
        repeat (HALF) @(negedge clk);
      end
    spi_sclk = 1'b0;
    repeat (HALF) @(negedge clk);
    spi_cs = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic check_fields(input string req);
    check({req, " cap_pc"},    32'(cap_pc),    32'(exp_pc));
    check({req, " cap_sel"},   32'(cap_sel),   32'(exp_sel));
    check({req, " safe_addr"}, 32'(safe_addr), 32'(exp_pa));
    check({req, " safe_data"}, 32'(safe_data), 32'(exp_pd));
  endtask

  task automatic cap_write(input logic [8:0] pc, input logic [1:0] sel, input int n);
    hdr(1'b0, CAP);
    tx_b[2] = {5'b0, pc[8:6]};
    tx_b[3] = {pc[5:0], sel};
    tx_b[4] = 8'hFF; tx_b[5] = 8'hA5;
    xfer(n);
  endtask

  task automatic safe_write(input logic [7:0] pa, input logic [21:0] pd, input int n);
    hdr(1'b0, SAFE);
    tx_b[2] = pa; tx_b[3] = {2'b00, pd[21:16]};
    tx_b[4] = pd[15:8]; tx_b[5] = pd[7:0];
    xfer(n);
  endtask

  task automatic cap_read(input logic [23:0] w, input int n);
    cap_word = w;
    hdr(1'b1, CAP);
    for (int b = 2; b < 8; b++) tx_b[b] = 8'h00;
    xfer(n);
  endtask

  task automatic t_reset;
    check("R8 miso after reset", 32'(spi_miso), 0);
    check("R9 no strobes after reset", cnt_cw + cnt_sw + cnt_cr, 0);
    check_fields("R9 reset");
  endtask

  task automatic t_cap_write;
    int c0;
    c0 = cnt_cw;
    cap_write(9'h1A5, 2'd2, 4);
    exp_pc = 9'h1A5; exp_sel = 2'd2;
    check("R2 cap_wr count", cnt_cw, c0 + 1);
    check_fields("R2 first");
    cap_write(9'h05A, 2'd1, 4);
    exp_pc = 9'h05A; exp_sel = 2'd1;
    check("R2 cap_wr count second", cnt_cw, c0 + 2);
    check_fields("R1 R2 second");
  endtask

  task automatic t_safe_write;
    int c0;
    c0 = cnt_sw;
    safe_write(8'h3C, 22'h2ABCDE, 6);
    exp_pa = 8'h3C; exp_pd = 22'h2ABCDE;
    check("R3 safe_wr count", cnt_sw, c0 + 1);
    check_fields("R3 first");
    safe_write(8'hC1, 22'h01_8001, 6);
    exp_pa = 8'hC1; exp_pd = 22'h01_8001;
    check("R3 safe_wr count second", cnt_sw, c0 + 2);
    check_fields("R3 second");
  endtask

  task automatic t_cap_read;
    int c0;
    c0 = cnt_cr;
    cap_read(24'hC3A55A, 6);
    check("R4 cap_rd count", cnt_cr, c0 + 1);
    check("R4 read word", {8'h0, rx_b[3], rx_b[4], rx_b[5]}, 32'hC3A55A);
    check("R8 miso low in header", {8'h0, rx_b[0], rx_b[1], rx_b[2]}, 0);
    cap_read(24'h817E01, 6);
    check("R4 read word second", {8'h0, rx_b[3], rx_b[4], rx_b[5]}, 32'h817E01);
    check("R4 cap_rd count second", cnt_cr, c0 + 2);
  endtask

  task automatic t_abort;
    int s0, c0;
    s0 = cnt_sw; c0 = cnt_cw;
    safe_write(8'h77, 22'h155555, 4);
    cap_write(9'h0F0, 2'd3, 3);
    check("R5 aborted safeload no strobe", cnt_sw, s0);
    check("R5 aborted capture no strobe", cnt_cw, c0);
    check_fields("R5 aborted");
    cap_write(9'h133, 2'd0, 4);
    exp_pc = 9'h133; exp_sel = 2'd0;
    check("R5 next frame decodes", cnt_cw, c0 + 1);
    check_fields("R5 after abort");
  endtask

  task automatic t_unknown;
    int s0;
    s0 = cnt_cw + cnt_sw + cnt_cr;
    hdr(1'b0, 10'h155);
    for (int b = 2; b < 6; b++) tx_b[b] = 8'h5A;
    xfer(6);
    check("R6 unknown write no strobe", cnt_cw + cnt_sw + cnt_cr, s0);
    cap_word = 24'hFFFFFF;
    hdr(1'b1, SAFE);
    for (int b = 2; b < 6; b++) tx_b[b] = 8'h00;
    xfer(6);
    check("R6 read of safeload addr miso", {rx_b[3], rx_b[4], rx_b[5]}, 0);
    check("R6 read of safeload addr no strobe", cnt_cw + cnt_sw + cnt_cr, s0);
    hdr(1'b0, CAP);
    tx_b[0] = tx_b[0] | 8'h40;
    tx_b[2] = 8'h01; tx_b[3] = 8'hFF;
    xfer(4);
    check("R1 reserved header bits nonzero", cnt_cw + cnt_sw + cnt_cr, s0);
    check_fields("R6 R1 unknown");
  endtask

  task automatic t_lockout;
    int s0;
    s0 = cnt_cw + cnt_sw + cnt_cr;
    boot_busy = 1'b1;
    cap_write(9'h1FF, 2'd3, 4);
    safe_write(8'hEE, 22'h3FFFFF, 6);
    cap_read(24'hABCDEF, 6);
    check("R7 read during boot miso", {rx_b[3], rx_b[4], rx_b[5]}, 0);
    boot_busy = 1'b0;
    check("R7 no strobe during boot", cnt_cw + cnt_sw + cnt_cr, s0);
    hdr(1'b0, CAP);
    tx_b[2] = 8'h01; tx_b[3] = 8'h0D;
    fork
      xfer(4);
      begin
        repeat (200) @(negedge clk); boot_busy = 1'b1;
        repeat (5) @(negedge clk);   boot_busy = 1'b0;
      end
    join
    check("R7 mid-frame lockout pulse", cnt_cw + cnt_sw + cnt_cr, s0);
    check_fields("R7 lockout");
  endtask

  task automatic t_long;
    int c0;
    cap_read(24'h9C3E71, 7);
    check("R8 byte after data miso", 32'(rx_b[6]), 0);
    check("R4 long read word", {8'h0, rx_b[3], rx_b[4], rx_b[5]}, 32'h9C3E71);
    c0 = cnt_cw;
    cap_write(9'h0C6, 2'd2, 6);
    exp_pc = 9'h0C6; exp_sel = 2'd2;
    check("R9 extra bytes single strobe", cnt_cw, c0 + 1);
    check_fields("R9 extra bytes");
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_cap_write();
    t_safe_write();
    t_cap_read();
    t_abort();
    t_unknown();
    t_lockout();
    t_long();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule